// File: doc/BRIEF.md
# DMA Cache-Line Request Unroller

This block turns one queued DMA descriptor into a series of bus requests, none of which crosses a 128-byte cache line of the main-memory (effective) address. A descriptor carries a 64-bit effective address, a local-store address, a byte count of up to 16 KB and a tag. The block walks the transfer one line at a time. A transfer that begins part-way into a line gets a short first request that reaches only to the end of that line. A transfer that ends part-way into a line gets a short last request. Every request between them is a full line of 8 quadwords.

Each request carries its effective address, its local address, a quadword count from 1 to 8, and flags that mark the first and the last request of the descriptor. Requests leave under a valid/ready handshake. A descriptor is taken only when the block is idle. In the cycle that the last request is accepted, a one-cycle done pulse carries the descriptor's tag. The asynchronous reset is released through an internal two-stage synchronizer.

Top module: `line_req_splitter`

## Requirements
- R1: After reset, `req_valid` and `done_valid` are 0 and `desc_ready` is 1.
- R2: `desc_ready` is 0 while a descriptor is being walked, and a `desc_valid` presented during that time has no effect on the requests.
- R3: Each request's quadword count is min(8 − EA[6:4], remaining quadwords), and is always between 1 and 8, so no request crosses a 128-byte line of the effective address.
- R4: The first request of a descriptor has `req_first`=1 and starts at the descriptor's address. When EA[6:4] is non-zero, that request is partial.
- R5: Every request that is neither first nor last carries 8 quadwords.
- R6: The last request has `req_last`=1 and covers exactly the quadwords that remain. A transfer that fits within one line gives a single request with both flags set.
- R7: After each accepted request, both the effective address and the local address advance by count × 16. The local address wraps at its own width.
- R8: While `req_valid`=1 and `req_ready`=0, every request output holds its value.
- R9: `done_valid` is 1 exactly in the cycle the last request is accepted, and `done_tag` equals the descriptor's tag.
- R10: Bits [3:0] of the descriptor's addresses and size are ignored (treated as 0). The counts of all requests add up to size/16. The largest size, 16384 bytes, is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_ea | input | 64 | Effective (main-memory) start address |
| desc_la | input | 18 | Local-store start address |
| desc_size | input | 15 | Transfer size in bytes, 16..16384 |
| desc_tag | input | 5 | Tag returned with the done pulse |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted when high together with valid |
| req_ea | output | 64 | Request effective address |
| req_la | output | 18 | Request local address |
| req_qw | output | 4 | Quadwords in this request, 1..8 |
| req_first | output | 1 | First request of the descriptor |
| req_last | output | 1 | Last request of the descriptor |
| done_valid | output | 1 | Pulse when the last request is accepted |
| done_tag | output | 5 | Tag of the completed descriptor |

## Verification
Each input pattern isolates one part of the splitting rule. A line-aligned transfer shows the all-full case. A start and an end both in mid-line separate the short first request and the short last request from the full middle ones. A transfer inside a single line shows both flags on one request. A maximum-size transfer with a one-quadword start offset runs the widest count and the longest walk. A start just below a 4 GB boundary, with a local address near its top, shows the carry into the upper effective-address bits and the wrap of the local address. Random-looking stalls on `req_ready`, and stray descriptors offered while busy, separate correct holding and gating from outputs that change too early.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int QW_SH = 4;  // log2 of bytes per quadword

  typedef enum logic {
    ST_IDLE,
    ST_EMIT
  } lrs_state_e;
endpackage

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lrs_chunk.sv
module lrs_chunk #(
  parameter int LINE_QW = 8,
  parameter int OFF_W   = 3,
  parameter int REM_W   = 11,
  parameter int CNT_W   = 4
) (
  input  logic [OFF_W-1:0] line_off,
  input  logic [REM_W-1:0] rem_qw,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic [CNT_W-1:0] room;
  logic [REM_W-1:0] room_ext;

  always_comb begin
    room     = CNT_W'(LINE_QW) - CNT_W'(line_off);
    room_ext = REM_W'(room);
    last     = (rem_qw <= room_ext);
    cnt      = last ? CNT_W'(rem_qw) : room;
  end
endmodule

// File: rtl/lrs_walker.sv
module lrs_walker
  import lrs_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int LA_W    = 18,
  parameter int SIZE_W  = 15,
  parameter int TAG_W   = 5,
  parameter int LINE_QW = 8,
  parameter int OFF_W   = 3,
  parameter int REM_W   = 11,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [EA_W-1:0]   desc_ea,
  input  logic [LA_W-1:0]   desc_la,
  input  logic [SIZE_W-1:0] desc_size,
  input  logic [TAG_W-1:0]  desc_tag,
  output logic              desc_ready,
  input  logic              req_ready,
  input  logic [CNT_W-1:0]  chunk_cnt,
  input  logic              chunk_last,
  output logic              req_valid,
  output logic [EA_W-1:0]   req_ea,
  output logic [LA_W-1:0]   req_la,
  output logic              req_first,
  output logic [REM_W-1:0]  rem_qw,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag
);
  lrs_state_e       state_q, state_n;
  logic [EA_W-1:0]  ea_q, ea_n;
  logic [LA_W-1:0]  la_q, la_n;
  logic [REM_W-1:0] rem_q, rem_n;
  logic             first_q, first_n;
  logic [TAG_W-1:0] tag_q, tag_n;
  logic             load, fire, en;
  logic [EA_W-1:0]  step;

  always_comb begin
    load    = desc_valid && (state_q == ST_IDLE) && rst_n;
    fire    = (state_q == ST_EMIT) && req_ready;
    en      = load || fire;
    step    = EA_W'({chunk_cnt, {QW_SH{1'b0}}});
    state_n = state_q;
    ea_n    = ea_q;
    la_n    = la_q;
    rem_n   = rem_q;
    first_n = first_q;
    tag_n   = tag_q;
    if (load) begin
      state_n = ST_EMIT;
      ea_n    = desc_ea & ~(EA_W'((1 << QW_SH) - 1));
      la_n    = desc_la & ~(LA_W'((1 << QW_SH) - 1));
      rem_n   = REM_W'(desc_size >> QW_SH);
      first_n = 1'b1;
      tag_n   = desc_tag;
    end else if (fire) begin
      ea_n    = ea_q + step;
      la_n    = la_q + LA_W'(step);
      rem_n   = rem_q - REM_W'(chunk_cnt);
      first_n = 1'b0;
      if (chunk_last) state_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      la_q    <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
      tag_q   <= '0;
    end else if (en) begin
      state_q <= state_n;
      ea_q    <= ea_n;
      la_q    <= la_n;
      rem_q   <= rem_n;
      first_q <= first_n;
      tag_q   <= tag_n;
    end
  end

  assign desc_ready = (state_q == ST_IDLE) && rst_n;
  assign req_valid  = (state_q == ST_EMIT);
  assign req_ea     = ea_q;
  assign req_la     = la_q;
  assign req_first  = first_q;
  assign rem_qw     = rem_q;
  assign done_valid = fire && chunk_last;
  assign done_tag   = tag_q;

  // R2: no descriptor intake while a walk is in progress
  p_busy_blocks_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !desc_ready);

  // R3: a request never runs past the end of its line
  p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (chunk_cnt != '0) &&
                  ((REM_W'(ea_q[OFF_W+QW_SH-1:QW_SH]) + REM_W'(chunk_cnt)) <= REM_W'(LINE_QW)));

  // R5: interior requests are whole lines
  p_middle_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !first_q && !chunk_last) |-> (chunk_cnt == CNT_W'(LINE_QW)));

  // R7: effective address steps by the accepted byte count
  p_ea_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !chunk_last) |=> (ea_q == $past(ea_q) + $past(step)));

  // R8: request held while stalled
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(ea_q) && $stable(la_q) &&
                                  $stable(chunk_cnt) && $stable(first_q) && $stable(chunk_last));

  // R9: done only on acceptance of the last request
  p_done_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (req_valid && req_ready && chunk_last));
endmodule

// File: rtl/line_req_splitter.sv
module line_req_splitter #(
  parameter int EA_W    = 64,
  parameter int LA_W    = 18,
  parameter int SIZE_W  = 15,
  parameter int TAG_W   = 5,
  parameter int LINE_QW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [EA_W-1:0]   desc_ea,
  input  logic [LA_W-1:0]   desc_la,
  input  logic [SIZE_W-1:0] desc_size,
  input  logic [TAG_W-1:0]  desc_tag,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [EA_W-1:0]   req_ea,
  output logic [LA_W-1:0]   req_la,
  output logic [$clog2(LINE_QW+1)-1:0] req_qw,
  output logic              req_first,
  output logic              req_last,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag
);
  localparam int OFF_W  = $clog2(LINE_QW);
  localparam int LINE_SH = lrs_pkg::QW_SH + OFF_W;
  localparam int REM_W  = SIZE_W - lrs_pkg::QW_SH;
  localparam int CNT_W  = $clog2(LINE_QW + 1);

  logic             srst_n;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic [REM_W-1:0] rem_qw;

  lrs_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  lrs_walker #(
    .EA_W(EA_W), .LA_W(LA_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W),
    .LINE_QW(LINE_QW), .OFF_W(OFF_W), .REM_W(REM_W), .CNT_W(CNT_W)
  ) i_walker (
    .clk        (clk),
    .rst_n      (srst_n),
    .desc_valid (desc_valid),
    .desc_ea    (desc_ea),
    .desc_la    (desc_la),
    .desc_size  (desc_size),
    .desc_tag   (desc_tag),
    .desc_ready (desc_ready),
    .req_ready  (req_ready),
    .chunk_cnt  (cnt),
    .chunk_last (last),
    .req_valid  (req_valid),
    .req_ea     (req_ea),
    .req_la     (req_la),
    .req_first  (req_first),
    .rem_qw     (rem_qw),
    .done_valid (done_valid),
    .done_tag   (done_tag)
  );

  lrs_chunk #(
    .LINE_QW(LINE_QW), .OFF_W(OFF_W), .REM_W(REM_W), .CNT_W(CNT_W)
  ) i_chunk (
    .line_off (req_ea[LINE_SH-1:lrs_pkg::QW_SH]),
    .rem_qw   (rem_qw),
    .cnt      (cnt),
    .last     (last)
  );

  assign req_qw   = cnt;
  assign req_last = last;
endmodule

// File: tb/test_line_req_splitter.sv
module test_line_req_splitter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_valid;
  logic        desc_ready;
  logic [63:0] desc_ea;
  logic [17:0] desc_la;
  logic [14:0] desc_size;
  logic [4:0]  desc_tag;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_ea;
  logic [17:0] req_la;
  logic [3:0]  req_qw;
  logic        req_first;
  logic        req_last;
  logic        done_valid;
  logic [4:0]  done_tag;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  line_req_splitter i_line_req_splitter (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_ea(desc_ea), .desc_la(desc_la), .desc_size(desc_size), .desc_tag(desc_tag),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_la(req_la), .req_qw(req_qw),
    .req_first(req_first), .req_last(req_last),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; desc_valid = 1'b0; req_ready = 1'b0;
    desc_ea = '0; desc_la = '0; desc_size = '0; desc_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(req_valid == 1'b0,  "R1", "req_valid",  64'(req_valid),  0);
    chk(done_valid == 1'b0, "R1", "done_valid", 64'(done_valid), 0);
    chk(desc_ready == 1'b1, "R1", "desc_ready", 64'(desc_ready), 1);
  endtask

  // Walk one descriptor; stall_mod>0 drops ready every stall_mod-th cycle,
  // poke offers junk descriptors while busy.
  task automatic run_xfer(input string nm, input logic [63:0] ea, input logic [17:0] la,
                          input logic [14:0] size, input logic [4:0] tag,
                          input int stall_mod, input bit poke);
    logic [63:0] m_ea;
    logic [17:0] m_la;
    int          m_rem;
    bit          m_first;
    int          sum;
    int          cyc;
    int          ecnt;
    bit          elast;
    bit          done_seen;
    m_ea = ea & ~64'hF;
    m_la = la & ~18'hF;
    m_rem = int'(size >> 4);
    m_first = 1'b1;
    sum = 0; cyc = 0; done_seen = 1'b0;
    @(negedge clk);
    desc_valid = 1'b1; desc_ea = ea; desc_la = la; desc_size = size; desc_tag = tag;
    req_ready = 1'b0;
    #1;
    chk(desc_ready == 1'b1, "R2", {nm, " desc_ready idle"}, 64'(desc_ready), 1);
    @(posedge clk);
    forever begin
      @(negedge clk);
      ecnt  = (m_rem < 8 - int'(m_ea[6:4])) ? m_rem : 8 - int'(m_ea[6:4]);
      elast = (m_rem == ecnt);
      req_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
      if (poke && !(elast && req_ready)) begin
        desc_valid = 1'b1; desc_ea = 64'hDEAD_0000_0000_0070; desc_la = 18'h00123;
        desc_size = 15'h0100; desc_tag = ~tag;
      end else begin
        desc_valid = 1'b0;
      end
      #1;
      chk(req_valid == 1'b1,  "R2", {nm, " req_valid"}, 64'(req_valid), 1);
      chk(desc_ready == 1'b0, "R2", {nm, " desc_ready busy"}, 64'(desc_ready), 0);
      chk(req_ea == m_ea,     "R7", {nm, " req_ea"}, req_ea, m_ea);
      chk(req_la == m_la,     "R7", {nm, " req_la"}, 64'(req_la), 64'(m_la));
      chk(int'(req_qw) == ecnt, "R3", {nm, " req_qw"}, 64'(req_qw), 64'(ecnt));
      chk(req_first == m_first, "R4", {nm, " req_first"}, 64'(req_first), 64'(m_first));
      chk(req_last == elast,  "R6", {nm, " req_last"}, 64'(req_last), 64'(elast));
      if (!m_first && !elast)
        chk(req_qw == 4'd8, "R5", {nm, " middle full"}, 64'(req_qw), 8);
      if (!req_ready)
        chk(done_valid == 1'b0, "R8", {nm, " no done while stalled"}, 64'(done_valid), 0);
      chk(done_valid == (req_ready && elast), "R9", {nm, " done_valid"},
          64'(done_valid), 64'(req_ready && elast));
      if (done_valid) begin
        done_seen = 1'b1;
        chk(done_tag == tag, "R9", {nm, " done_tag"}, 64'(done_tag), 64'(tag));
      end
      cyc++;
      @(posedge clk);
      if (req_ready) begin
        sum += ecnt;
        m_ea = m_ea + 64'(ecnt * 16);
        m_la = m_la + 18'(ecnt * 16);
        m_rem -= ecnt;
        m_first = 1'b0;
        if (elast) break;
      end
    end
    @(negedge clk);
    desc_valid = 1'b0; req_ready = 1'b0;
    #1;
    chk(req_valid == 1'b0,  "R6", {nm, " idle after last"}, 64'(req_valid), 0);
    chk(desc_ready == 1'b1, "R2", {nm, " ready after last"}, 64'(desc_ready), 1);
    chk(done_seen,          "R9", {nm, " done seen"}, 64'(done_seen), 1);
    chk(sum == int'(size >> 4), "R10", {nm, " quadword total"}, 64'(sum), 64'(size >> 4));
  endtask

  task automatic t_aligned();
    run_xfer("aligned", 64'h1000_0000_0000_0400, 18'h00800, 15'd512, 5'd3, 0, 1'b0);
  endtask

  task automatic t_mid_both();
    run_xfer("mid_both", 64'h0000_0042_0000_1030, 18'h01030, 15'h0200, 5'd17, 3, 1'b1);
  endtask

  task automatic t_single_line();
    run_xfer("single", 64'h0000_0000_0000_2020, 18'h00020, 15'd48, 5'd9, 2, 1'b0);
  endtask

  task automatic t_carry_wrap();
    run_xfer("carry", 64'h0000_0000_FFFF_FFC0, 18'h3FFC0, 15'd256, 5'd30, 0, 1'b1);
  endtask

  task automatic t_max_size();
    run_xfer("max", 64'h0000_0001_0000_0010, 18'h00010, 15'h4000, 5'd31, 4, 1'b0);
  endtask

  task automatic t_low_bits();
    run_xfer("lowbits", 64'h0000_0000_0000_0047, 18'h0004F, 15'h003F, 5'd5, 0, 1'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_aligned();
    t_mid_both();
    t_single_line();
    t_carry_wrap();
    t_max_size();
    t_low_bits();
    finish_run();
  end
endmodule